// File: doc/BRIEF.md
# SPI-to-BiSS Data Mailbox

This block is a one-way mailbox that carries a data word from an SPI host to a BiSS master. It reuses the position counter storage as the mailbox. The SPI engine delivers byte writes into a six-byte address window. The BiSS engine takes a parallel snapshot of channel 0, shifts it out, and then signals that the read is over.

A two-bit width code selects how many bytes make up the word. A word counts as delivered when the SPI side writes the highest byte that the selected width needs. At that point a valid flag rises. The BiSS side sees this flag as its active-low warning bit. The error bit, also active low, shows that the host had written some lower bytes of a new word but had not yet finished it when the snapshot was taken.

The snapshot frame holds the data word, right-aligned and masked to the selected width. The error bit and the warning bit follow it in the two least significant bits. After a completed read, the valid flag drops, so the same word is never reported twice.

Top module: `spi_biss_mailbox`

## Requirements
- R1: After reset the valid flag is 0, the frame is 0x3 (data zero, error bit 1, warning bit 1), and the frame length is 18.
- R2: A write to address 0x20+k (k from 0 to 5) stores its byte as bits 8k+7..8k of the word, so byte 0x20 is the least significant. The word read out is right-aligned.
- R3: Width code 0, 1, 2 and 3 select 16, 24, 32 and 48 data bits. The frame length reported with a snapshot is the width plus 2, and data bits at or above the width read as zero.
- R4: A write to address 0x20+n-1, where n is the byte count of the selected width, sets the valid flag on the clock edge of that write.
- R5: Writes to lower window bytes, or to bytes above the selected width, leave the valid flag unchanged. Writes outside 0x20..0x25 change no stored byte.
- R6: Frame bit 0 (warning) is the inverse of the valid flag as it stood before the snapshot request edge.
- R7: Frame bit 1 (error) is 0 when a window byte below the top byte has been written since the last completing write; otherwise it is 1.
- R8: A read-done pulse after a snapshot request clears the valid flag, unless a completing write happened after (or in the same cycle as) that request; in that case the flag stays 1.
- R9: The frame and the frame length hold their values until the next snapshot request, whatever writes or width changes happen meanwhile.
- R10: A read-done pulse with no snapshot request outstanding has no effect on the valid flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Byte write strobe from the SPI engine |
| wrAddr | input | 8 | Byte write address |
| wrData | input | 8 | Byte write data |
| widthSel | input | 2 | Word width code (0:16, 1:24, 2:32, 3:48 bits) |
| rdReq | input | 1 | BiSS engine takes a channel-0 snapshot |
| rdDone | input | 1 | BiSS engine finished shifting channel 0 |
| frameData | output | 50 | Snapshot: data word, then error bit, then warning bit |
| frameLen | output | 6 | Bit count of the snapshot frame |
| validFlag | output | 1 | Live mailbox valid flag |

## Verification
The bench builds the block with its defaults: a six-byte window at base 0x20 and an 8-bit address. At that size every width code can be swept with every window byte written in ascending order, and the valid flag can be checked after each single byte. All 256 values of the lowest byte are pushed through a full write-and-read round trip at 16-bit width. The small window also lets the bench probe the addresses just outside both ends, and create partial-word, rearm-during-read and stray read-done cases directly.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int unsigned MBX_BYTES = 6;
  localparam int unsigned MBX_BITS  = 8 * MBX_BYTES;
  localparam int unsigned FRAME_W   = MBX_BITS + 2;
  localparam int unsigned LEN_W     = $clog2(FRAME_W + 1);
  localparam int unsigned IDX_W     = $clog2(MBX_BYTES);

  typedef enum logic [1:0] {
    WIDTH16 = 2'd0,
    WIDTH24 = 2'd1,
    WIDTH32 = 2'd2,
    WIDTH48 = 2'd3
  } widthCode_e;

  // control-to-datapath strobes
  typedef struct packed {
    logic [MBX_BYTES-1:0] byteWe;
    logic                 snap;
    logic                 errN;
    logic                 warnN;
  } dpStrobe_t;

  function automatic logic [IDX_W:0] bytesFor(input logic [1:0] code);
    case (widthCode_e'(code))
      WIDTH16: bytesFor = (IDX_W+1)'(2);
      WIDTH24: bytesFor = (IDX_W+1)'(3);
      WIDTH32: bytesFor = (IDX_W+1)'(4);
      default: bytesFor = (IDX_W+1)'(6);
    endcase
  endfunction
endpackage

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [1:0]        widthSel,
  input  logic              rdReq,
  input  logic              rdDone,
  output dpStrobe_t         strb,
  output logic              validFlag
);
  logic [ADDR_W-1:0] offset;
  logic              inWindow;
  logic [IDX_W:0]    topIdx;
  logic [MBX_BYTES-1:0] byteWe;
  logic              complete;
  logic              lowWrite;
  logic              validQ, partialQ, readingQ, rearmQ;

  assign offset   = wrAddr - BASE_ADDR;
  assign inWindow = offset < ADDR_W'(MBX_BYTES);
  assign topIdx   = bytesFor(widthSel) - (IDX_W+1)'(1);

  for (genvar k = 0; k < MBX_BYTES; k++) begin : g_dec
    assign byteWe[k] = wrEn && inWindow && (offset == ADDR_W'(k));
  end

  assign complete = byteWe[topIdx];
  assign lowWrite = wrEn && inWindow && (offset < ADDR_W'(topIdx));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ   <= 1'b0;
      partialQ <= 1'b0;
      readingQ <= 1'b0;
      rearmQ   <= 1'b0;
    end else begin
      if (complete)                              validQ <= 1'b1;
      else if (rdDone && readingQ && !rearmQ && !rdReq) validQ <= 1'b0;

      if (complete)      partialQ <= 1'b0;
      else if (lowWrite) partialQ <= 1'b1;

      if (rdReq)       readingQ <= 1'b1;
      else if (rdDone) readingQ <= 1'b0;

      if (rdReq)                     rearmQ <= complete;
      else if (rdDone)               rearmQ <= 1'b0;
      else if (complete && readingQ) rearmQ <= 1'b1;
    end
  end

  always_comb begin
    strb.byteWe = byteWe;
    strb.snap   = rdReq;
    strb.errN   = !partialQ;
    strb.warnN  = !validQ;
  end

  assign validFlag = validQ;

  // R4: completing write raises valid
  p_set_on_complete_r4: assert property (@(posedge clk) disable iff (!rstN)
    complete |=> validQ);
  // R8: finished read with no new data clears valid
  p_clear_on_done_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rdDone && !rdReq && readingQ && !rearmQ && !complete) |=> !validQ);
  // R8: new data during the read keeps valid
  p_keep_on_rearm_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rdDone && readingQ && rearmQ) |=> validQ);
  // R10: no read outstanding, valid holds
  p_idle_done_r10: assert property (@(posedge clk) disable iff (!rstN)
    (validQ && !readingQ) |=> validQ);
  // R7: completing write clears the partial marker
  p_err_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    complete |=> !partialQ);
endmodule

// File: rtl/mbox_dp.sv
module mbox_dp
  import mbox_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [7:0]         wrData,
  input  logic [1:0]         widthSel,
  input  dpStrobe_t          strb,
  output logic [FRAME_W-1:0] frameData,
  output logic [LEN_W-1:0]   frameLen
);
  logic [MBX_BITS-1:0] wordQ;
  logic [MBX_BITS-1:0] maskedWord;
  logic [IDX_W:0]      nBytes;
  logic [FRAME_W-1:0]  frameQ;
  logic [LEN_W-1:0]    lenQ;

  assign nBytes = bytesFor(widthSel);

  for (genvar k = 0; k < MBX_BYTES; k++) begin : g_byte
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               wordQ[8*k +: 8] <= 8'h00;
      else if (strb.byteWe[k]) wordQ[8*k +: 8] <= wrData;
    end
    assign maskedWord[8*k +: 8] = ((IDX_W+1)'(k) < nBytes) ? wordQ[8*k +: 8] : 8'h00;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameQ <= FRAME_W'(3);
      lenQ   <= LEN_W'(18);
    end else if (strb.snap) begin
      frameQ <= {maskedWord, strb.errN, strb.warnN};
      lenQ   <= LEN_W'({nBytes, 3'b000}) + LEN_W'(2);
    end
  end

  assign frameData = frameQ;
  assign frameLen  = lenQ;

  // R3: only the four legal lengths ever appear
  p_len_legal_r3: assert property (@(posedge clk) disable iff (!rstN)
    (lenQ == LEN_W'(18)) || (lenQ == LEN_W'(26)) ||
    (lenQ == LEN_W'(34)) || (lenQ == LEN_W'(50)));
endmodule

// File: rtl/spi_biss_mailbox.sv
module spi_biss_mailbox
  import mbox_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [7:0]         wrAddr,
  input  logic [7:0]         wrData,
  input  logic [1:0]         widthSel,
  input  logic               rdReq,
  input  logic               rdDone,
  output logic [FRAME_W-1:0] frameData,
  output logic [LEN_W-1:0]   frameLen,
  output logic               validFlag
);
  dpStrobe_t strb;

  mbox_ctrl #(.ADDR_W(8), .BASE_ADDR(8'h20)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .widthSel(widthSel), .rdReq(rdReq), .rdDone(rdDone),
    .strb(strb), .validFlag(validFlag)
  );

  mbox_dp dp_i (
    .clk(clk), .rstN(rstN), .wrData(wrData), .widthSel(widthSel),
    .strb(strb), .frameData(frameData), .frameLen(frameLen)
  );

  // R6: warning bit mirrors valid before the snapshot
  p_warn_tracks_r6: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |=> (frameData[0] == !$past(validFlag)));
  // R9: frame holds between snapshots
  p_frame_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !rdReq |=> ($stable(frameData) && $stable(frameLen)));
endmodule

// File: tb/spi_biss_mailbox_tb_top.sv
module spi_biss_mailbox_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [7:0] wrAddr = 8'h00, wrData = 8'h00;
  logic [1:0] widthSel = 2'd0;
  logic rdReq = 1'b0, rdDone = 1'b0;
  logic [49:0] frameData;
  logic [5:0]  frameLen;
  logic validFlag;

  int errs = 0, checks = 0;
  logic [7:0] mdl [6];
  bit finished = 0;

  always #2 clk = ~clk;

  spi_biss_mailbox dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .widthSel(widthSel), .rdReq(rdReq), .rdDone(rdDone),
    .frameData(frameData), .frameLen(frameLen), .validFlag(validFlag)
  );

  function automatic int nb(input logic [1:0] w);
    return (w == 2'd3) ? 6 : int'(w) + 2;
  endfunction

  function automatic logic [49:0] expFrame(input logic [1:0] w, input bit e, input bit v);
    logic [49:0] f = '0;
    for (int k = 0; k < nb(w); k++) f[8*k+2 +: 8] = mdl[k];
    f[1] = e;
    f[0] = v;
    return f;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
    if (a >= 8'h20 && a <= 8'h25) mdl[a - 8'h20] = d;
  endtask

  task automatic req();
    @(negedge clk); rdReq = 1'b1;
    @(negedge clk); rdReq = 1'b0;
  endtask

  task automatic done();
    @(negedge clk); rdDone = 1'b1;
    @(negedge clk); rdDone = 1'b0;
  endtask

  initial begin
    #400000;
    if (!finished) begin
      errs++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [49:0] held;
    for (int k = 0; k < 6; k++) mdl[k] = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 valid", 64'(validFlag), 64'd0);
    chk("R1 frame", 64'(frameData), 64'h3);
    chk("R1 len", 64'(frameLen), 64'd18);

    // R2 R3 R4 R5 sweep of widths, bytes written ascending
    for (int w = 0; w < 4; w++) begin
      widthSel = 2'(w);
      for (int k = 0; k < 6; k++) begin
        wr(8'h20 + 8'(k), 8'((k + 1) * 37 + w * 91));
        chk((k < nb(2'(w)) - 1) ? "R5 valid early" : "R4 valid set",
            64'(validFlag), 64'(k >= nb(2'(w)) - 1));
      end
      req();
      chk("R2 R3 frame", 64'(frameData), 64'(expFrame(2'(w), 1'b1, 1'b0)));
      chk("R3 len", 64'(frameLen), 64'(8 * nb(2'(w)) + 2));
      done();
      chk("R8 cleared", 64'(validFlag), 64'd0);
    end

    // R5 out-of-window writes ignored
    widthSel = 2'd3;
    wr(8'h1F, 8'hFF); wr(8'h26, 8'hFF); wr(8'h00, 8'hFF);
    chk("R5 oow valid", 64'(validFlag), 64'd0);
    req();
    chk("R5 oow data", 64'(frameData), 64'(expFrame(2'd3, 1'b1, 1'b1)));
    done();

    // R7 partial word
    widthSel = 2'd0;
    wr(8'h20, 8'hA5);
    req();
    chk("R7 err low", 64'(frameData[1:0]), 64'b01);
    done();
    wr(8'h21, 8'h5A);
    req();
    chk("R7 err high", 64'(frameData), 64'(expFrame(2'd0, 1'b1, 1'b0)));

    // R9 hold during writes and width change
    held = frameData;
    wr(8'h20, 8'h00); wr(8'h22, 8'h77);
    widthSel = 2'd3;
    repeat (2) @(negedge clk);
    chk("R9 frame held", 64'(frameData), 64'(held));
    chk("R9 len held", 64'(frameLen), 64'd18);
    widthSel = 2'd0;
    done();
    // 0x21 not rewritten: valid cleared
    chk("R8 clear", 64'(validFlag), 64'd0);

    // R8 rearm: completion during read keeps valid
    wr(8'h20, 8'h01); wr(8'h21, 8'h02);
    req();
    wr(8'h21, 8'h03);
    done();
    chk("R8 rearm kept", 64'(validFlag), 64'd1);
    req();
    chk("R6 warn", 64'(frameData[0]), 64'd0);
    done();
    chk("R8 cleared2", 64'(validFlag), 64'd0);

    // R10 stray done
    wr(8'h21, 8'h04);
    done();
    chk("R10 stray done", 64'(validFlag), 64'd1);
    req(); done();

    // R2 exhaustive low byte at 16-bit width
    for (int v = 0; v < 256; v++) begin
      wr(8'h20, 8'(v)); wr(8'h21, 8'(~v));
      req();
      chk("R2 byte sweep", 64'(frameData), 64'(expFrame(2'd0, 1'b1, 1'b0)));
      done();
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule